// File: doc/BRIEF.md
# YCbCr to RGB DAC Code Matrix

This block turns 4:4:4 studio-range YCbCr pixels into three 10-bit codes that drive red, green and blue video DACs. Each pixel arrives as 8-bit luma and two 8-bit chroma samples with a valid strobe, at up to one pixel per clock. The block takes the mid-scale offset off both chroma samples and weights the colour differences with fixed-point coefficients. It then maps the result onto the DAC code scale, where luma 16 lands on code 232 and luma 235 on code 670. Any result outside the 10-bit range saturates.

Results leave a three-register pipeline together with a delayed valid. A separate enable bit per colour channel travels with each pixel. When the bit is clear, that channel shows the blanking code for that pixel. Upstream logic does the chroma upsampling. Sync insertion and the analogue converters sit downstream.

Top module: `ycc2rgb_matrix`

## Requirements
- R1: With Cb = Cr = 128, every enabled channel outputs 2*Y + 200, so Y = 16 gives 232 and Y = 235 gives 670.
- R2: Red equals 2*Y + 200 + round(2*1404*(Cr-128) / 1024). Cb has no effect on red.
- R3: Green equals 2*Y + 200 + round(-(2*715*(Cr-128) + 2*344*(Cb-128)) / 1024). Both chroma products are summed at full precision before the single rounding.
- R4: Blue equals 2*Y + 200 + round(2*1774*(Cb-128) / 1024). Cr has no effect on blue.
- R5: Rounding is to nearest, and exact halves go towards plus infinity. Y=16, Cr=192 gives red 408. Y=16, Cr=64 gives red 57.
- R6: A channel result below 0 outputs code 0. Example: Y=0, Cb=0 gives blue 0.
- R7: A channel result above 1023 outputs code 1023. Example: Y=255, Cb=255 gives blue 1023.
- R8: A pixel captured at clock edge k appears on the outputs after edge k+2. out_valid is high for exactly that cycle.
- R9: While out_valid is low, all three output codes hold their previous values. Inputs presented with in_valid low never change the outputs.
- R10: ch_en bit 0 gates red, bit 1 gates green and bit 2 gates blue. A clear bit forces that channel to 232 for that pixel only. The other channels are unaffected.
- R11: During reset and after it, until the first pixel arrives, out_valid is 0 and all three codes are 232.
- R12: Pixels presented on consecutive clocks leave on consecutive clocks, in the same order, each with its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel strobe for in_y, in_cb, in_cr, ch_en |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue colour-difference sample, offset 128 |
| in_cr | input | 8 | Red colour-difference sample, offset 128 |
| ch_en | input | 3 | Per-channel enable: bit 0 red, bit 1 green, bit 2 blue |
| out_valid | output | 1 | High when the three codes carry a new pixel |
| out_r | output | 10 | Red DAC code |
| out_g | output | 10 | Green DAC code |
| out_b | output | 10 | Blue DAC code |

## Verification
The bench targets the exact-half rounding points on both sides of mid-scale chroma. A design that rounds halves away from zero, or one that truncates, lands one code off at Cr = 64 or Cr = 192. It drives extreme luma with extreme chroma to reach both saturation limits, where missing clamping would wrap to a code near the opposite end of the scale. It idles the strobe while the data inputs change and gates one channel at a time. This exposes outputs that follow unqualified inputs, and an enable that is applied in the wrong cycle or to the wrong colour. It also counts edges from capture to output and streams back-to-back pixels, which catches an extra or missing register and any mix-up between neighbouring pixels.

// File: rtl/ycc2rgb_pkg.sv
package ycc2rgb_pkg;

    localparam int NUM_CH = 3;

    typedef enum int unsigned {
        CH_R = 0,
        CH_G = 1,
        CH_B = 2
    } chan_e;

    // Colour-difference weights in thousandths.
    localparam int W_R_FROM_CR = 1371;
    localparam int W_G_FROM_CR = 698;
    localparam int W_G_FROM_CB = 336;
    localparam int W_B_FROM_CB = 1732;

    // Convert a weight in thousandths to a fixed-point value with `frac` fraction bits, rounded.
    function automatic int milli_to_fixed(input int milli, input int frac);
        return (milli * (1 << frac) + 500) / 1000;
    endfunction

endpackage

// File: rtl/ycc_center_stage.sv
module ycc_center_stage
    import ycc2rgb_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CHROMA_MID = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_y,
    input  logic [DATA_W-1:0]        in_cb,
    input  logic [DATA_W-1:0]        in_cr,
    input  logic [NUM_CH-1:0]        in_en,
    output logic                     s1_valid,
    output logic [DATA_W-1:0]        s1_y,
    output logic signed [DATA_W:0]   s1_cb,
    output logic signed [DATA_W:0]   s1_cr,
    output logic [NUM_CH-1:0]        s1_en
);

    localparam logic signed [DATA_W:0] MID_S = (DATA_W+1)'(CHROMA_MID);

    typedef struct packed {
        logic                   valid;
        logic [DATA_W-1:0]      y;
        logic signed [DATA_W:0] cb;
        logic signed [DATA_W:0] cr;
        logic [NUM_CH-1:0]      en;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.y  = in_y;
            st_d.cb = $signed({1'b0, in_cb}) - MID_S;
            st_d.cr = $signed({1'b0, in_cr}) - MID_S;
            st_d.en = in_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s1_valid = st_q.valid;
    assign s1_y     = st_q.y;
    assign s1_cb    = st_q.cb;
    assign s1_cr    = st_q.cr;
    assign s1_en    = st_q.en;

endmodule

// File: rtl/ycc_product_stage.sv
module ycc_product_stage
    import ycc2rgb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int FRAC_BITS   = 10,
    parameter int LUMA_GAIN   = 2,
    parameter int LUMA_OFFSET = 200,
    parameter int TERM_W      = 24,
    parameter int BASE_W      = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s1_valid,
    input  logic [DATA_W-1:0]        s1_y,
    input  logic signed [DATA_W:0]   s1_cb,
    input  logic signed [DATA_W:0]   s1_cr,
    input  logic [NUM_CH-1:0]        s1_en,
    output logic                     s2_valid,
    output logic [NUM_CH-1:0]        s2_en,
    output logic signed [BASE_W-1:0] s2_base,
    output logic signed [TERM_W-1:0] s2_term_r,
    output logic signed [TERM_W-1:0] s2_term_g,
    output logic signed [TERM_W-1:0] s2_term_b
);

    // Weights already scaled by the luma-to-code gain.
    localparam int K_R_CR = LUMA_GAIN * milli_to_fixed(W_R_FROM_CR, FRAC_BITS);
    localparam int K_G_CR = LUMA_GAIN * milli_to_fixed(W_G_FROM_CR, FRAC_BITS);
    localparam int K_G_CB = LUMA_GAIN * milli_to_fixed(W_G_FROM_CB, FRAC_BITS);
    localparam int K_B_CB = LUMA_GAIN * milli_to_fixed(W_B_FROM_CB, FRAC_BITS);

    typedef struct packed {
        logic                     valid;
        logic [NUM_CH-1:0]        en;
        logic signed [BASE_W-1:0] base;
        logic signed [TERM_W-1:0] term_r;
        logic signed [TERM_W-1:0] term_g;
        logic signed [TERM_W-1:0] term_b;
    } st_t;

    st_t st_d, st_q;
    int  cb_i, cr_i, y_i;

    always_comb begin
        cb_i       = int'(s1_cb);
        cr_i       = int'(s1_cr);
        y_i        = int'(s1_y);
        st_d       = st_q;
        st_d.valid = s1_valid;
        if (s1_valid) begin
            st_d.en     = s1_en;
            st_d.base   = BASE_W'(LUMA_GAIN * y_i + LUMA_OFFSET);
            st_d.term_r = TERM_W'(K_R_CR * cr_i);
            st_d.term_g = TERM_W'(-(K_G_CR * cr_i + K_G_CB * cb_i));
            st_d.term_b = TERM_W'(K_B_CB * cb_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s2_valid  = st_q.valid;
    assign s2_en     = st_q.en;
    assign s2_base   = st_q.base;
    assign s2_term_r = st_q.term_r;
    assign s2_term_g = st_q.term_g;
    assign s2_term_b = st_q.term_b;

endmodule

// File: rtl/ycc_sum_clamp.sv
module ycc_sum_clamp #(
    parameter int CODE_W     = 10,
    parameter int FRAC_BITS  = 10,
    parameter int TERM_W     = 24,
    parameter int BASE_W     = 13,
    parameter int CODE_BLACK = 232
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_en,
    input  logic signed [BASE_W-1:0] in_base,
    input  logic signed [TERM_W-1:0] in_term,
    output logic [CODE_W-1:0]        code
);

    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int HALF     = 1 << (FRAC_BITS - 1);

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } st_t;

    st_t st_d, st_q;
    int  sum_i;

    always_comb begin
        sum_i = int'(in_base) + ((int'(in_term) + HALF) >>> FRAC_BITS);
        st_d  = st_q;
        if (in_valid) begin
            if (!in_en) begin
                st_d.code = CODE_W'(CODE_BLACK);
            end else if (sum_i < 0) begin
                st_d.code = '0;
            end else if (sum_i > CODE_MAX) begin
                st_d.code = CODE_W'(CODE_MAX);
            end else begin
                st_d.code = CODE_W'(sum_i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.code <= CODE_W'(CODE_BLACK);
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;

endmodule

// File: rtl/ycc2rgb_matrix.sv
module ycc2rgb_matrix
    import ycc2rgb_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CODE_W     = 10,
    parameter int FRAC_BITS  = 10,
    parameter int CHROMA_MID = 128,
    parameter int Y_BLACK    = 16,
    parameter int Y_WHITE    = 235,
    parameter int CODE_BLACK = 232,
    parameter int CODE_WHITE = 670
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_y,
    input  logic [DATA_W-1:0] in_cb,
    input  logic [DATA_W-1:0] in_cr,
    input  logic [2:0]        ch_en,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_r,
    output logic [CODE_W-1:0] out_g,
    output logic [CODE_W-1:0] out_b
);

    localparam int LUMA_GAIN   = (CODE_WHITE - CODE_BLACK) / (Y_WHITE - Y_BLACK);
    localparam int LUMA_OFFSET = CODE_BLACK - LUMA_GAIN * Y_BLACK;
    localparam int TERM_W      = DATA_W + FRAC_BITS + 6;
    localparam int BASE_W      = CODE_W + 3;

    logic                     s1_valid;
    logic [DATA_W-1:0]        s1_y;
    logic signed [DATA_W:0]   s1_cb, s1_cr;
    logic [NUM_CH-1:0]        s1_en;

    logic                     s2_valid;
    logic [NUM_CH-1:0]        s2_en;
    logic signed [BASE_W-1:0] s2_base;
    logic signed [TERM_W-1:0] s2_term_r, s2_term_g, s2_term_b;

    logic signed [TERM_W-1:0] term_arr [NUM_CH];
    logic [CODE_W-1:0]        code_arr [NUM_CH];

    ycc_center_stage #(
        .DATA_W     (DATA_W),
        .CHROMA_MID (CHROMA_MID)
    ) u_center (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_y     (in_y),
        .in_cb    (in_cb),
        .in_cr    (in_cr),
        .in_en    (ch_en),
        .s1_valid (s1_valid),
        .s1_y     (s1_y),
        .s1_cb    (s1_cb),
        .s1_cr    (s1_cr),
        .s1_en    (s1_en)
    );

    ycc_product_stage #(
        .DATA_W      (DATA_W),
        .FRAC_BITS   (FRAC_BITS),
        .LUMA_GAIN   (LUMA_GAIN),
        .LUMA_OFFSET (LUMA_OFFSET),
        .TERM_W      (TERM_W),
        .BASE_W      (BASE_W)
    ) u_product (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_y      (s1_y),
        .s1_cb     (s1_cb),
        .s1_cr     (s1_cr),
        .s1_en     (s1_en),
        .s2_valid  (s2_valid),
        .s2_en     (s2_en),
        .s2_base   (s2_base),
        .s2_term_r (s2_term_r),
        .s2_term_g (s2_term_g),
        .s2_term_b (s2_term_b)
    );

    assign term_arr[CH_R] = s2_term_r;
    assign term_arr[CH_G] = s2_term_g;
    assign term_arr[CH_B] = s2_term_b;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        ycc_sum_clamp #(
            .CODE_W     (CODE_W),
            .FRAC_BITS  (FRAC_BITS),
            .TERM_W     (TERM_W),
            .BASE_W     (BASE_W),
            .CODE_BLACK (CODE_BLACK)
        ) u_sum (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (s2_valid),
            .in_en    (s2_en[ch]),
            .in_base  (s2_base),
            .in_term  (term_arr[ch]),
            .code     (code_arr[ch])
        );
    end

    // Output strobe register, aligned with the per-channel code registers.
    typedef struct packed {
        logic valid;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = s2_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_r     = code_arr[CH_R];
    assign out_g     = code_arr[CH_G];
    assign out_b     = code_arr[CH_B];

endmodule

// File: rtl/ycc2rgb_checker.sv
module ycc2rgb_checker #(
    parameter int DATA_W     = 8,
    parameter int CODE_W     = 10,
    parameter int CHROMA_MID = 128,
    parameter int CODE_BLACK = 232
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_cb,
    input logic [DATA_W-1:0] in_cr,
    input logic [2:0]        ch_en,
    input logic              out_valid,
    input logic [CODE_W-1:0] out_r,
    input logic [CODE_W-1:0] out_g,
    input logic [CODE_W-1:0] out_b
);

    localparam logic [DATA_W-1:0] MID    = DATA_W'(CHROMA_MID);
    localparam logic [CODE_W-1:0] BLANKC = CODE_W'(CODE_BLACK);

    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 3));

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_r) && $stable(out_g) && $stable(out_b)));

    assert_red_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(ch_en[0], 3)) |-> out_r == BLANKC);

    assert_green_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(ch_en[1], 3)) |-> out_g == BLANKC);

    assert_blue_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(ch_en[2], 3)) |-> out_b == BLANKC);

    assert_grey_equal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_cb, 3) == MID && $past(in_cr, 3) == MID
         && $past(ch_en, 3) == 3'b111) |-> (out_r == out_g && out_g == out_b));

endmodule

bind ycc2rgb_matrix ycc2rgb_checker #(
    .DATA_W     (DATA_W),
    .CODE_W     (CODE_W),
    .CHROMA_MID (CHROMA_MID),
    .CODE_BLACK (CODE_BLACK)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_cb     (in_cb),
    .in_cr     (in_cr),
    .ch_en     (ch_en),
    .out_valid (out_valid),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b)
);

// File: tb/tb_ycc2rgb_matrix.sv
`timescale 1ns/1ps
module tb_ycc2rgb_matrix;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [7:0] in_y, in_cb, in_cr;
    logic [2:0] ch_en;
    logic       out_valid;
    logic [9:0] out_r, out_g, out_b;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ycc2rgb_matrix dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_y      (in_y),
        .in_cb     (in_cb),
        .in_cr     (in_cr),
        .ch_en     (ch_en),
        .out_valid (out_valid),
        .out_r     (out_r),
        .out_g     (out_g),
        .out_b     (out_b)
    );

    function automatic int model(int ch, int y, int cb, int cr, int en);
        int t;
        int s;
        if (((en >> ch) & 1) == 0) return 232;
        case (ch)
            0:       t = 2 * 1404 * (cr - 128);
            1:       t = -(2 * 715 * (cr - 128) + 2 * 344 * (cb - 128));
            default: t = 2 * 1774 * (cb - 128);
        endcase
        s = 2 * y + 200 + ((t + 512) >>> 10);
        if (s < 0) s = 0;
        if (s > 1023) s = 1023;
        return s;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one pixel, leave at the negedge after its result is on the outputs.
    task automatic push_one(int y, int cb, int cr, int en);
        @(negedge clk);
        in_valid = 1'b1;
        in_y = 8'(y); in_cb = 8'(cb); in_cr = 8'(cr); ch_en = 3'(en);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pixel_check(string req, int y, int cb, int cr, int en);
        push_one(y, cb, cr, en);
        check(req, "valid", int'(out_valid), 1);
        check(req, "red",   int'(out_r), model(0, y, cb, cr, en));
        check(req, "green", int'(out_g), model(1, y, cb, cr, en));
        check(req, "blue",  int'(out_b), model(2, y, cb, cr, en));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_y = '0; in_cb = '0; in_cr = '0; ch_en = '0;
        repeat (4) @(negedge clk);
        check("R11", "valid in reset", int'(out_valid), 0);
        check("R11", "red in reset", int'(out_r), 232);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R11", "valid after reset", int'(out_valid), 0);
        check("R11", "green after reset", int'(out_g), 232);
        check("R11", "blue after reset", int'(out_b), 232);
    endtask

    task automatic t_grey();
        push_one(16, 128, 128, 7);
        check("R1", "black red", int'(out_r), 232);
        check("R1", "black blue", int'(out_b), 232);
        push_one(235, 128, 128, 7);
        check("R1", "white red", int'(out_r), 670);
        check("R1", "white green", int'(out_g), 670);
        check("R1", "white blue", int'(out_b), 670);
        pixel_check("R1", 100, 128, 128, 7);
    endtask

    task automatic t_red();
        pixel_check("R2", 80, 128, 200, 7);
        pixel_check("R2", 80, 30, 200, 7);
        pixel_check("R2", 120, 240, 40, 7);
    endtask

    task automatic t_green();
        pixel_check("R3", 150, 60, 190, 7);
        pixel_check("R3", 90, 220, 20, 7);
        pixel_check("R3", 130, 129, 127, 7);
    endtask

    task automatic t_blue();
        pixel_check("R4", 70, 210, 128, 7);
        pixel_check("R4", 70, 210, 16, 7);
        pixel_check("R4", 200, 50, 240, 7);
    endtask

    task automatic t_round();
        push_one(16, 128, 192, 7);
        check("R5", "positive half red", int'(out_r), 408);
        push_one(16, 128, 64, 7);
        check("R5", "negative half red", int'(out_r), 57);
    endtask

    task automatic t_saturate();
        push_one(0, 0, 128, 7);
        check("R6", "low clamp blue", int'(out_b), 0);
        push_one(255, 255, 128, 7);
        check("R7", "high clamp blue", int'(out_b), 1023);
        pixel_check("R6", 0, 255, 0, 7);
        pixel_check("R7", 255, 0, 255, 7);
    endtask

    task automatic t_latency();
        @(negedge clk);
        in_valid = 1'b1; in_y = 8'd60; in_cb = 8'd100; in_cr = 8'd170; ch_en = 3'b111;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", "valid after 1 edge", int'(out_valid), 0);
        @(negedge clk);
        check("R8", "valid after 2 edges", int'(out_valid), 0);
        @(negedge clk);
        check("R8", "valid after 3 edges", int'(out_valid), 1);
        check("R8", "red after 3 edges", int'(out_r), model(0, 60, 100, 170, 7));
        @(negedge clk);
        check("R8", "valid after 4 edges", int'(out_valid), 0);
    endtask

    task automatic t_hold();
        int r0, g0, b0;
        push_one(180, 70, 210, 7);
        r0 = int'(out_r); g0 = int'(out_g); b0 = int'(out_b);
        in_y = 8'd5; in_cb = 8'd250; in_cr = 8'd3; ch_en = 3'b000;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_y = 8'(in_y + 8'd37);
            check("R9", "idle valid", int'(out_valid), 0);
            check("R9", "idle red", int'(out_r), r0);
            check("R9", "idle green", int'(out_g), g0);
            check("R9", "idle blue", int'(out_b), b0);
        end
    endtask

    task automatic t_enable();
        pixel_check("R10", 140, 60, 200, 3'b101);
        check("R10", "green gated", int'(out_g), 232);
        pixel_check("R10", 140, 60, 200, 3'b010);
        check("R10", "red gated", int'(out_r), 232);
        pixel_check("R10", 140, 60, 200, 3'b011);
        check("R10", "blue gated", int'(out_b), 232);
        pixel_check("R10", 140, 60, 200, 3'b111);
    endtask

    task automatic t_stream();
        int ys [6] = '{20, 235, 90, 0, 255, 128};
        int cbs[6] = '{128, 16, 240, 0, 255, 64};
        int crs[6] = '{240, 16, 128, 100, 255, 192};
        int ens[6] = '{7, 7, 6, 7, 3, 7};
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            if (k >= 3) begin
                check("R12", "stream valid", int'(out_valid), 1);
                check("R12", "stream red", int'(out_r),
                      model(0, ys[k-3], cbs[k-3], crs[k-3], ens[k-3]));
                check("R12", "stream green", int'(out_g),
                      model(1, ys[k-3], cbs[k-3], crs[k-3], ens[k-3]));
                check("R12", "stream blue", int'(out_b),
                      model(2, ys[k-3], cbs[k-3], crs[k-3], ens[k-3]));
            end
            if (k < 6) begin
                in_valid = 1'b1;
                in_y = 8'(ys[k]); in_cb = 8'(cbs[k]); in_cr = 8'(crs[k]); ch_en = 3'(ens[k]);
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_grey();
        t_red();
        t_green();
        t_blue();
        t_round();
        t_saturate();
        t_latency();
        t_hold();
        t_enable();
        t_stream();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule